// File: doc/BRIEF.md
# Framed Parallel-to-Serial Transmitter

This block turns 24-bit parallel words into a fixed-rate serial stream. A word is presented together with a strobe. On a rising edge of the strobe the word is taken into a single holding slot. The strobe is asynchronous to the bit clock and is brought into that domain by a flop chain. Separately, a one-cycle frame-start pulse marks each reference period. On that pulse the transmitter launches a 26-bit frame: two word-boundary bits, then the payload from the most significant bit to the least.

The strobe is decoupled from the frame rate. A frame with nothing new in the holding slot still goes out, with an all-zero payload, so the line always carries 26 bits per reference period. A word that is overwritten before a frame picks it up raises a sticky overrun flag. Words that arrive before the clock-ready input is high are dropped. While the transmit enable is high, the receive-side word-clock output is held high. Dropping the enable silences and clears the transmitter.

Top module: `ser_frame_tx`

## Requirements
- R1: The edge that samples `frame_start` high with `tx_enable` high loads a frame. Bit 0 of the frame drives `ser_out` from that edge, and bit i from i edges later, for 26 bits. Bit 0 is 1, bit 1 is 0, and bits 2..25 are the payload from `word_in[23]` down to `word_in[0]`.
- R2: A strobe rising edge is taken on the third rising edge of `clk` counting the first edge that samples `strobe` high. `word_in` is captured on that edge.
- R3: A frame loaded while no word is pending carries the boundary bits 1,0 followed by 24 zero payload bits, and `data_valid` stays low during it.
- R4: `data_valid` is high for exactly the 26 bit cycles of a frame that was loaded from a pending word, and low otherwise.
- R5: Loading a frame consumes the pending word, so each captured word is sent in exactly one frame.
- R6: A second capture while a word is still pending and no load happens on that edge replaces the word, so the newer word is sent. It also sets `overrun`, which stays high until reset or until `tx_enable` goes low.
- R7: A capture on the same edge as a frame load sends the older pending word in that frame, keeps the new word pending for the next frame, and does not set `overrun`.
- R8: A strobe edge detected while `clk_ready` is low is discarded and is never sent.
- R9: While `tx_enable` is low, frame-start pulses and strobes have no effect, and the pending word and `overrun` are cleared. From the next edge on, `ser_out` and `data_valid` are low. `word_clk_out` equals `tx_enable`.
- R10: While `rst` is high, each edge clears the pending word, the overrun flag, the synchronizer and the frame shifter, so `ser_out`, `data_valid` and `overrun` read 0.
- R11: After the last bit of a frame, with no new frame-start pulse, `ser_out` stays low and `data_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit path enable |
| clk_ready | input | 1 | Clock-ready indication; captures are dropped while low |
| frame_start | input | 1 | One-cycle pulse marking the start of a reference period |
| strobe | input | 1 | Asynchronous word strobe; its rising edge captures the word |
| word_in | input | 24 | Parallel word |
| ser_out | output | 1 | Serial frame bit |
| data_valid | output | 1 | High while the frame on the line carries a captured word |
| word_clk_out | output | 1 | Receive-side word clock, held high while transmitting |
| overrun | output | 1 | Sticky flag: a pending word was overwritten |

## Verification
A strobe first sampled high on edge k is captured on edge k+2. Bit i of a frame whose `frame_start` was sampled on edge E is on `ser_out` after edge E+i. `data_valid` and `overrun` change on the same edges as the load and the capture that cause them. The bench's reference model updates on each rising edge from the inputs as they were sampled there. The outputs are compared with it on the following falling edge, so each result is checked in the cycle where it is due. Strobe pulses are placed at fixed offsets within the frame so that captures land at chosen distances from a load, including on the load edge itself.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;

    parameter int unsigned PAYLOAD_W  = 24;
    parameter int unsigned BOUNDARY_W = 2;
    parameter int unsigned FRAME_W    = PAYLOAD_W + BOUNDARY_W;

    // boundary marker leads each frame, first bit at the MSB
    parameter logic [BOUNDARY_W-1:0] BOUNDARY_PAT = 2'b10;

    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] word;
        logic                 pending;
    } hold_t;

    function automatic logic [FRAME_W-1:0] build_frame(input hold_t h);
        logic [PAYLOAD_W-1:0] body;
        body = h.pending ? h.word : '0;
        return {BOUNDARY_PAT, body};
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic rise_o
);
    // STAGES flops for metastability plus one for the edge compare
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], strobe_i};
        end
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/word_holder.sv
module word_holder
    import ser_frame_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable_i,
    input  logic                 ready_i,
    input  logic                 rise_i,
    input  logic                 take_i,
    input  logic [PAYLOAD_W-1:0] word_i,
    output hold_t                hold_o,
    output logic                 overrun_o
);
    hold_t slot;
    logic  ovr;
    logic  capture;

    assign capture = enable_i & ready_i & rise_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            ovr  <= 1'b0;
        end else if (!enable_i) begin
            slot.pending <= 1'b0;
            ovr          <= 1'b0;
        end else if (capture) begin
            slot.word    <= word_i;
            slot.pending <= 1'b1;
            if (slot.pending && !take_i) begin
                ovr <= 1'b1;
            end
        end else if (take_i) begin
            slot.pending <= 1'b0;
        end
    end

    assign hold_o    = slot;
    assign overrun_o = ovr;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import ser_frame_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_i,
    input  logic               frame_start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               frame_valid_i,
    output logic               take_o,
    output logic               ser_o,
    output logic               valid_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    tx_state_e          state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               valid_q;

    assign take_o = enable_i & frame_start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_OFF;
            shreg   <= '0;
            bit_cnt <= '0;
            valid_q <= 1'b0;
        end else if (!enable_i) begin
            state   <= TX_OFF;
            shreg   <= '0;
            bit_cnt <= '0;
            valid_q <= 1'b0;
        end else if (frame_start_i) begin
            state   <= TX_SEND;
            shreg   <= frame_i;
            bit_cnt <= '0;
            valid_q <= frame_valid_i;
        end else begin
            case (state)
                TX_SEND: begin
                    shreg <= {shreg[FRAME_W-2:0], 1'b0};
                    if (bit_cnt == LAST_BIT) begin
                        state   <= TX_IDLE;
                        bit_cnt <= '0;
                        valid_q <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                TX_OFF:  state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign ser_o   = shreg[FRAME_W-1];
    assign valid_o = valid_q;
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
    import ser_frame_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_enable,
    input  logic                 clk_ready,
    input  logic                 frame_start,
    input  logic                 strobe,
    input  logic [PAYLOAD_W-1:0] word_in,
    output logic                 ser_out,
    output logic                 data_valid,
    output logic                 word_clk_out,
    output logic                 overrun
);
    logic               strobe_rise;
    logic               take;
    hold_t              hold;
    logic [FRAME_W-1:0] next_frame;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .rise_o   (strobe_rise)
    );

    word_holder u_hold (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (tx_enable),
        .ready_i   (clk_ready),
        .rise_i    (strobe_rise),
        .take_i    (take),
        .word_i    (word_in),
        .hold_o    (hold),
        .overrun_o (overrun)
    );

    assign next_frame = build_frame(hold);

    frame_shifter u_shift (
        .clk           (clk),
        .rst           (rst),
        .enable_i      (tx_enable),
        .frame_start_i (frame_start),
        .frame_i       (next_frame),
        .frame_valid_i (hold.pending),
        .take_o        (take),
        .ser_o         (ser_out),
        .valid_o       (data_valid)
    );

    // receive side stays parked with its word clock high while sending
    assign word_clk_out = tx_enable;
endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_enable,
    input logic frame_start,
    input logic ser_out,
    input logic data_valid,
    input logic overrun
);
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!ser_out && !data_valid && !overrun)); // R10

    AST_FRAME_HEAD: assert property (@(posedge clk) disable iff (rst)
        (frame_start && tx_enable) |=> ser_out); // R1

    AST_FRAME_SECOND: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && !frame_start && $past(frame_start && tx_enable && !rst))
        |=> !ser_out); // R1

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> (!ser_out && !data_valid && !overrun)); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && tx_enable) |=> overrun); // R6

    AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(frame_start && tx_enable)); // R4
endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_enable   (tx_enable),
    .frame_start (frame_start),
    .ser_out     (ser_out),
    .data_valid  (data_valid),
    .overrun     (overrun)
);

// File: tb/test_ser_frame_tx.sv
module test_ser_frame_tx;
    localparam int FRM = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0;
    logic        clk_ready = 1'b0;
    logic        frame_start = 1'b0;
    logic        strobe = 1'b0;
    logic [23:0] word_in = '0;
    logic        ser_out, data_valid, word_clk_out, overrun;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string phase    = "R10";
    bit    started  = 0;

    // stimulus scheduler state
    bit          frames_on = 0;
    int          fcnt      = 0;
    bit          st_req    = 0;
    int          st_slot   = 0;
    int          st_len    = 0;
    logic [23:0] st_word   = '0;

    // reference model state
    bit          sq[$];
    int          fq[$];
    logic [23:0] hold_m = '0;
    bit          pend_m = 0;
    bit          ovr_m  = 0;
    bit          val_m  = 0;

    ser_frame_tx i_ser_frame_tx (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .clk_ready(clk_ready),
        .frame_start(frame_start), .strobe(strobe), .word_in(word_in),
        .ser_out(ser_out), .data_valid(data_valid),
        .word_clk_out(word_clk_out), .overrun(overrun)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic request_strobe(input int slot, input logic [23:0] w);
        st_slot = slot;
        st_word = w;
        st_req  = 1;
        wait (st_req == 0);
        #1;
    endtask

    // reference model: advances on the same edge as the design
    initial begin
        sq = '{0, 0, 0};
    end

    always @(posedge clk) begin
        bit det, load;
        started = 1;
        if (rst) begin
            sq = '{0, 0, 0};
            pend_m = 0; ovr_m = 0; val_m = 0; hold_m = '0;
            fq.delete();
        end else begin
            det  = sq[1] && !sq[2];
            load = tx_enable && frame_start;
            if (!tx_enable) begin
                pend_m = 0; ovr_m = 0; val_m = 0;
                fq.delete();
            end else begin
                if (load) begin
                    fq.delete();
                    fq.push_back(1);
                    fq.push_back(0);
                    for (int i = 23; i >= 0; i--)
                        fq.push_back(pend_m ? int'(hold_m[i]) : 0);
                    val_m = pend_m;
                end else if (fq.size() > 0) begin
                    void'(fq.pop_front());
                    if (fq.size() == 0) val_m = 0;
                end
                if (det && clk_ready) begin
                    if (pend_m && !load) ovr_m = 1;
                    hold_m = word_in;
                    pend_m = 1;
                end else if (load) begin
                    pend_m = 0;
                end
            end
            sq.push_front(strobe);
            void'(sq.pop_back());
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started) begin
            check(phase, "ser_out", int'(ser_out), fq.size() > 0 ? fq[0] : 0);
            check(phase, "data_valid", int'(data_valid), int'(val_m));
            check(phase, "overrun", int'(overrun), int'(ovr_m));
            check("R9", "word_clk_out", int'(word_clk_out), int'(tx_enable));
        end
    end

    // frame pulses and strobe pulses placed at frame offsets
    initial begin
        forever begin
            @(negedge clk);
            frame_start = frames_on && (fcnt == 0);
            if (st_len > 0) begin
                st_len--;
                if (st_len == 0) begin
                    strobe = 0;
                    st_req = 0;
                end
            end else if (st_req && fcnt == st_slot) begin
                strobe  = 1;
                word_in = st_word;
                st_len  = 4;
            end
            fcnt = (fcnt + 1) % FRM;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        wait_cycles(3);
        check("R10", "ser_out in reset", int'(ser_out), 0);
        check("R10", "data_valid in reset", int'(data_valid), 0);
        check("R10", "overrun in reset", int'(overrun), 0);
        rst = 0;
        tx_enable = 1;
        wait_cycles(2);
        frames_on = 1;

        // R8 with R3: capture before clock ready is dropped, frames are empty
        phase = "R8/R3";
        request_strobe(5, 24'hA5A5A5);
        wait_cycles(3 * FRM);
        check("R8", "data_valid after dropped word", int'(data_valid), 0);

        // R1, R2, R4, R5: single words sent once, MSB first
        clk_ready = 1;
        phase = "R1/R2/R4/R5";
        request_strobe(5, 24'hC3_0F_81);
        wait_cycles(3 * FRM);
        request_strobe(10, 24'h800001);
        wait_cycles(2 * FRM);
        request_strobe(20, 24'hFFFFFF);
        wait_cycles(2 * FRM);

        // R6: two captures inside one frame period
        phase = "R6";
        request_strobe(3, 24'h123456);
        request_strobe(14, 24'h654321);
        wait_cycles(3 * FRM);
        check("R6", "overrun after overwrite", int'(overrun), 1);

        // R9: disable mid-frame with a pending word, strobe while off
        phase = "R9";
        request_strobe(2, 24'h0BEEF0);
        wait_cycles(FRM + 6);
        tx_enable = 0;
        request_strobe(8, 24'h777777);
        wait_cycles(20);
        check("R9", "ser_out while off", int'(ser_out), 0);
        check("R9", "overrun cleared while off", int'(overrun), 0);
        check("R9", "word_clk_out while off", int'(word_clk_out), 0);
        tx_enable = 1;
        wait_cycles(3 * FRM);
        check("R9", "word_clk_out while on", int'(word_clk_out), 1);

        // R7: capture on the load edge
        phase = "R7";
        request_strobe(10, 24'hABCDEF);
        wait_cycles(FRM);
        request_strobe(24, 24'h13579B);
        wait_cycles(3 * FRM);
        check("R7", "no overrun on load-edge capture", int'(overrun), 0);

        // R11: line idles after the last frame
        frames_on = 0;
        phase = "R11";
        wait_cycles(3 * FRM);
        check("R11", "ser_out idle", int'(ser_out), 0);
        check("R11", "data_valid idle", int'(data_valid), 0);

        finish_run();
    end
endmodule